// File: doc/BRIEF.md
# Sixteen-Bit Burst Line-Fill Responder

This block sits on the memory side of a 16-bit processor bus and serves cache line fills. One line is 16 bytes, and the block returns it as eight halfword beats. When the processor raises the start strobe while the block is idle, the block captures three things: the doubleword address, the three cycle-type qualifiers (memory/IO, write/read, data/code) and the line index. From then on it walks the line on its own. It produces each halfword address, reads that halfword from an internal array and pulses ready once per beat.

The first beat always starts on a doubleword boundary and returns both bytes, whatever byte enables the processor drives at that moment. On later beats the block honours the live byte enables. Both halfwords of a doubleword are returned before the next doubleword, the lower one first. The doublewords follow the interleaved order that the starting doubleword selects.

The processor can close the burst on any beat with its last-beat strobe. Otherwise the burst closes after the eighth beat. A fixed number of wait states, set by a parameter, comes before every beat. A simple load port fills the array before use.

Top module: `lfill_responder`

## Requirements
- R1: `cycleStart` sampled high while `busy` is low starts a burst, and `busy` is high from the next clock.
- R2: Beat 0 uses address `{reqAddr[ADDR_W-1:4], reqAddr[3:2], 2'b00}` and reports `beatByteEn = 2'b11`, whatever value `byteEn` has.
- R3: Beat b (0..7) addresses byte offset `4*(s ^ (b>>1)) + 2*(b&1)` within the line, where s is `reqAddr[3:2]`. This gives the doubleword orders 0,4,8,C / 4,0,C,8 / 8,C,0,4 / C,8,4,0, with the lower halfword of each doubleword first.
- R4: For the whole burst, `beatAddr[ADDR_W-1:4]` and `heldQual` keep the values captured at the start, even when `reqAddr` and `reqQual` change.
- R5: On beats 1..7, `beatByteEn` equals `byteEn`. Bit 0 enables byte [7:0] and bit 1 enables byte [15:8]. The data byte of a disabled lane reads as zero.
- R6: `rdData` carries the array halfword at index `beatAddr[IDX_W:1]`, masked as R5 and R2 require.
- R7: If `lastBeat` is high in a cycle where `beatReady` is high, that is the final beat: the next cycle has `busy` and `beatReady` low.
- R8: A burst without `lastBeat` ends after exactly eight ready beats and then returns to idle.
- R9: `beatReady` is high for one clock per beat. The first beat comes WAIT_STATES+1 clocks after the start edge, and each later beat comes WAIT_STATES+1 clocks after the one before.
- R10: `cycleStart` has no effect while a burst is running.
- R11: When `loadEn` is high at a clock edge, `loadData` is written to array index `loadAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStart | input | 1 | Burst start strobe |
| reqAddr | input | ADDR_W-2 | Doubleword address, bits ADDR_W-1:2 |
| reqQual | input | 3 | Cycle qualifiers: memory/IO, write/read, data/code |
| byteEn | input | 2 | Active-high byte enables for the current beat |
| lastBeat | input | 1 | Marks the current beat as the final one |
| loadEn | input | 1 | Array write strobe |
| loadAddr | input | IDX_W | Array write index |
| loadData | input | 16 | Array write data |
| beatReady | output | 1 | Data valid for this beat |
| beatAddr | output | ADDR_W | Byte address of the current halfword |
| beatByteEn | output | 2 | Byte lanes in effect for this beat |
| rdData | output | 16 | Read data, with disabled lanes zeroed |
| heldQual | output | 3 | Qualifiers captured at burst start |
| busy | output | 1 | Burst in progress |

## Verification
The hardest condition to create is a burst in which the inputs keep changing while the beats run. The bench has to show that the captured line bits and qualifiers stay put. It also has to show that a fresh start strobe is ignored and that beat 0 stays immune to its byte enables. To get there, every beat after the first drives an inverted address, inverted qualifiers, a start strobe and rotating byte enables, and beat 0 drives all enables off. A sweep covers every line offset for full bursts and every stop beat for every starting doubleword.

// File: rtl/lfill_pkg.sv
package lfill_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BEAT} lfState_e;

  typedef struct packed {
    logic capture;  // latch request, clear beat index
    logic advance;  // step to the next halfword
  } dpCtl_t;
endpackage

// File: rtl/lfill_ctrl.sv
module lfill_ctrl
  import lfill_pkg::*;
#(
  parameter int WAIT_STATES = 0
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   cycleStart,
  input  logic   lastBeat,
  input  logic   finalIdx,
  output dpCtl_t ctl,
  output logic   beatReady,
  output logic   busy
);
  localparam int WCW = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
  localparam bit NO_WAIT = (WAIT_STATES == 0);
  localparam logic [WCW-1:0] WAIT_LOAD = (WAIT_STATES > 0) ? WCW'(WAIT_STATES - 1) : '0;

  lfState_e state, stateNxt;
  logic [WCW-1:0] waitCnt, waitCntNxt;
  logic endBurst;

  always_comb begin
    beatReady = (state == ST_BEAT);
    busy = (state != ST_IDLE);
    endBurst = beatReady && (lastBeat || finalIdx);
    ctl.capture = (state == ST_IDLE) && cycleStart;
    ctl.advance = beatReady && !endBurst;
  end

  always_comb begin
    stateNxt = state;
    waitCntNxt = waitCnt;
    unique case (state)
      ST_IDLE: if (cycleStart) begin
        stateNxt = NO_WAIT ? ST_BEAT : ST_WAIT;
        waitCntNxt = WAIT_LOAD;
      end
      ST_WAIT: begin
        if (waitCnt == '0) stateNxt = ST_BEAT;
        else waitCntNxt = waitCnt - 1'b1;
      end
      ST_BEAT: begin
        if (endBurst) stateNxt = ST_IDLE;
        else if (!NO_WAIT) begin
          stateNxt = ST_WAIT;
          waitCntNxt = WAIT_LOAD;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNxt;
      waitCnt <= waitCntNxt;
    end
  end

  // R1: an accepted start makes the block busy
  a_r1_start_accepted: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cycleStart) |=> busy);
  // R7: a strobed beat is the final one
  a_r7_strobe_ends: assert property (@(posedge clk) disable iff (!rstN)
    (beatReady && lastBeat) |=> (!busy && !beatReady));
  // R8: the eighth beat always closes the burst
  a_r8_eight_max: assert property (@(posedge clk) disable iff (!rstN)
    (beatReady && finalIdx) |=> !busy);
  // R10: a start strobe mid-burst does not restart or end it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !beatReady && cycleStart) |=> busy);

  generate
    if (NO_WAIT) begin : g_nowait
      // R9: zero wait states -> ready on the clock after the start
      a_r9_first_ready: assert property (@(posedge clk) disable iff (!rstN)
        (!busy && cycleStart) |=> beatReady);
    end else begin : g_wait
      // R9: a ready beat is always followed by a wait cycle
      a_r9_ready_gap: assert property (@(posedge clk) disable iff (!rstN)
        beatReady |=> !beatReady);
    end
  endgenerate
endmodule

// File: rtl/lfill_dp.sv
module lfill_dp
  import lfill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MEM_HWORDS = 64,
  localparam int IDX_W = $clog2(MEM_HWORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:2] reqAddr,
  input  logic [2:0]        reqQual,
  input  logic [1:0]        byteEn,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadAddr,
  input  logic [15:0]       loadData,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [1:0]        beatByteEn,
  output logic [15:0]       rdData,
  output logic [2:0]        heldQual,
  output logic              finalIdx
);
  logic [ADDR_W-1:4] lineAddr;
  logic [1:0] startDw;
  logic [2:0] beatIdx;
  logic [1:0] curDw;
  logic [15:0] memWord;
  logic [15:0] mem [MEM_HWORDS];

  always_ff @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineAddr <= '0;
      startDw <= '0;
      beatIdx <= '0;
      heldQual <= '0;
    end else if (ctl.capture) begin
      lineAddr <= reqAddr[ADDR_W-1:4];
      startDw <= reqAddr[3:2];
      beatIdx <= '0;
      heldQual <= reqQual;
    end else if (ctl.advance) begin
      beatIdx <= beatIdx + 3'd1;
    end
  end

  always_comb begin
    curDw = startDw ^ beatIdx[2:1];
    beatAddr = {lineAddr, curDw, beatIdx[0], 1'b0};
    beatByteEn = (beatIdx == 3'd0) ? 2'b11 : byteEn;
    memWord = mem[beatAddr[IDX_W:1]];
    rdData = {beatByteEn[1] ? memWord[15:8] : 8'h00,
              beatByteEn[0] ? memWord[7:0] : 8'h00};
    finalIdx = (beatIdx == 3'd7);
  end

  // R2: the first beat after a capture is doubleword aligned with both lanes on
  a_r2_first_aligned: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (beatAddr[1] == 1'b0 && beatByteEn == 2'b11));
  // R3: every advance moves to a different halfword of the same line
  a_r3_new_halfword: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (beatAddr[3:1] != $past(beatAddr[3:1])));
  // R4: the line and qualifiers do not move while stepping
  a_r4_line_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> ($stable(beatAddr[ADDR_W-1:4]) && $stable(heldQual)));
endmodule

// File: rtl/lfill_responder.sv
module lfill_responder
  import lfill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MEM_HWORDS = 64,
  parameter int WAIT_STATES = 0,
  localparam int IDX_W = $clog2(MEM_HWORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStart,
  input  logic [ADDR_W-1:2] reqAddr,
  input  logic [2:0]        reqQual,
  input  logic [1:0]        byteEn,
  input  logic              lastBeat,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadAddr,
  input  logic [15:0]       loadData,
  output logic              beatReady,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [1:0]        beatByteEn,
  output logic [15:0]       rdData,
  output logic [2:0]        heldQual,
  output logic              busy
);
  dpCtl_t ctl;
  logic finalIdx;

  lfill_ctrl #(.WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .lastBeat(lastBeat),
    .finalIdx(finalIdx), .ctl(ctl), .beatReady(beatReady), .busy(busy)
  );

  lfill_dp #(.ADDR_W(ADDR_W), .MEM_HWORDS(MEM_HWORDS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqQual(reqQual),
    .byteEn(byteEn), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .beatAddr(beatAddr), .beatByteEn(beatByteEn), .rdData(rdData),
    .heldQual(heldQual), .finalIdx(finalIdx)
  );
endmodule

// File: tb/lfill_responder_tb.sv
module lfill_responder_tb;
  localparam int WAITS = 0;
  localparam int HW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleStart = 1'b0;
  logic [31:2] reqAddr = '0;
  logic [2:0] reqQual = '0;
  logic [1:0] byteEn = '0;
  logic lastBeat = 1'b0;
  logic loadEn = 1'b0;
  logic [5:0] loadAddr = '0;
  logic [15:0] loadData = '0;
  logic beatReady, busy;
  logic [31:0] beatAddr;
  logic [1:0] beatByteEn;
  logic [15:0] rdData;
  logic [2:0] heldQual;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  lfill_responder #(.ADDR_W(32), .MEM_HWORDS(HW), .WAIT_STATES(WAITS)) u_dut (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .reqAddr(reqAddr),
    .reqQual(reqQual), .byteEn(byteEn), .lastBeat(lastBeat), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData), .beatReady(beatReady),
    .beatAddr(beatAddr), .beatByteEn(beatByteEn), .rdData(rdData),
    .heldQual(heldQual), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] pattern(int i);
    return 16'((i * 16'h1357) ^ 16'h2C4B);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runBurst(logic [31:0] addr, int stopAt, logic [1:0] bePat, logic [2:0] q);
    int nb;
    logic [1:0] dw;
    logic [31:0] expAddr;
    logic [1:0] expBe;
    logic [15:0] word, expData;
    nb = (stopAt < 8) ? stopAt + 1 : 8;
    @(negedge clk);
    reqAddr = addr[31:2]; reqQual = q; cycleStart = 1'b1; lastBeat = 1'b0;
    @(negedge clk);
    cycleStart = 1'b0;
    for (int b = 0; b < nb; b++) begin
      for (int w = 0; w < WAITS; w++) begin
        #1 check(beatReady == 1'b0, "R9", "ready during wait", 32'(beatReady), 0);
        @(negedge clk);
      end
      byteEn = (b == 0) ? 2'b00 : 2'(bePat + 2'(b));
      lastBeat = (b == stopAt);
      if (b > 0) begin  // R4 R10: disturb inputs mid-burst
        cycleStart = 1'b1; reqAddr = ~addr[31:2]; reqQual = ~q;
      end
      #1;
      dw = addr[3:2] ^ 2'(b >> 1);
      expAddr = {addr[31:4], dw, 1'(b & 1), 1'b0};
      expBe = (b == 0) ? 2'b11 : byteEn;
      word = pattern(int'(expAddr[6:1]));
      expData = {expBe[1] ? word[15:8] : 8'h00, expBe[0] ? word[7:0] : 8'h00};
      check(beatReady == 1'b1, "R9", "ready on beat", 32'(beatReady), 1);
      check(beatAddr == expAddr, (b == 0) ? "R2" : "R3", "beat address", beatAddr, expAddr);
      check(beatByteEn == expBe, (b == 0) ? "R2" : "R5", "byte enables", 32'(beatByteEn), 32'(expBe));
      check(rdData == expData, "R6", "read data", 32'(rdData), 32'(expData));
      check(heldQual == q, "R4", "held qualifiers", 32'(heldQual), 32'(q));
      @(negedge clk);
    end
    cycleStart = 1'b0; lastBeat = 1'b0;
    #1;
    check(!busy && !beatReady, (stopAt < 8) ? "R7" : "R8", "idle after burst",
          {busy, beatReady}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check(!busy && !beatReady && heldQual == 3'b000, "R1", "reset state",
             {busy, beatReady, heldQual}, 0);
    rstN = 1'b1;
    for (int i = 0; i < HW; i++) begin  // R11: fill array through load port
      @(negedge clk);
      loadEn = 1'b1; loadAddr = 6'(i); loadData = pattern(i);
    end
    @(negedge clk);
    loadEn = 1'b0;
    // R1: start accepted, busy next cycle
    @(negedge clk);
    reqAddr = 30'h0; cycleStart = 1'b1; lastBeat = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    #1 check(busy == 1'b1, "R1", "busy after start", 32'(busy), 1);
    @(negedge clk);
    lastBeat = 1'b0;
    #1 check(busy == 1'b0, "R7", "single-beat burst done", 32'(busy), 0);
    // R3 R8: full bursts from every offset of every line
    for (int ln = 0; ln < 8; ln++)
      for (int off = 0; off < 16; off++)
        runBurst(32'hABC0_0000 | 32'(ln * 16 + off), 8, 2'(off), 3'(ln));
    // R7: early stop at each beat for every start doubleword
    for (int s = 0; s < 4; s++)
      for (int st = 0; st < 8; st++)
        runBurst(32'h1234_5650 | 32'(s * 4), st, 2'(st), 3'(s + st));
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule